// File: doc/BRIEF.md
# Two-Endpoint Interrupt IN Handshake Responder

This block sits in a low-speed USB device function, after the token decoder and before the packet serializer. When the host sends an IN token to one of the two non-control endpoints, the block chooses the reply. The reply is a data packet, NAK, STALL, or no reply. For a data reply it also supplies the data PID, the byte count and the read address into an eight-byte transmit buffer. Both endpoints use that one buffer. A single owner-select input decides which of the two endpoints the buffer serves. An IN token to the endpoint that does not own the buffer gets a NAK.

Software controls the data toggle completely. The block copies the toggle-select bit into the PID of every data reply and never changes the bit itself. A transmit-done flag sets once the last byte has been handed to the serializer. While it is set, every further IN token gets a NAK, until software acknowledges the flag. A separate remote wake-up control drives the bus lines into the K state. A resume-detected flag records K states from the host but ignores the K state that the block drives itself.

Top module: `intr_in_responder`

## Requirements
- R1: `pid_data1` is the toggle-select bit value captured when a data reply is decided (1 means DATA1, 0 means DATA0). The toggle-select bit changes only through its software write strobe and is never changed by sending.
- R2: Endpoint 1 is number 1 and endpoint 2 is number 2 on `tok_ep`. With `owner_ep2`=1 only endpoint 2 may get data. With `owner_ep2`=0 only endpoint 1 may get data. A token to the endpoint that does not own the buffer gets NAK if every other data condition holds.
- R3: The handshake is NAK (`hs_kind`=2) when transmit enable is 0 or `tx_done` is 1, provided the endpoint is enabled and not stalled.
- R4: An enabled endpoint whose stall bit is set gets STALL (`hs_kind`=3), whatever the NAK and data conditions are.
- R5: A token to a disabled endpoint, or to any endpoint number other than 1 or 2, gets no reply (`hs_kind`=0). Data is `hs_kind`=1.
- R6: `hs_valid` is high for exactly the one clock that follows a clock with `tok_valid` high. `hs_kind`, `pid_data1` and `send_len` are valid during that clock.
- R7: `send_len` equals the byte-count field when the field is 0 to 8. Field values 9 to 15 give 8.
- R8: After a data reply, `rd_addr` starts at 0 and rises by one on each `byte_req` pulse, up to `send_len`-1. `tx_busy` is high while bytes remain. A `byte_req` with `tx_busy` low changes nothing.
- R9: `tx_done` sets on the clock of the `byte_req` that consumes the last byte, or together with `hs_valid` for a zero-length reply. `done_ack` clears it.
- R10: Reset clears the toggle-select bit, transmit enable, the byte-count field, `tx_done`, `tx_busy` and `resume_seen`.
- R11: `bus_force_k` follows `force_resume` one clock later. `rx_k_state` sets `resume_seen` only if `force_resume` is 0 in that clock and in the clock before it. `resume_ack` clears `resume_seen`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | input | 1 | One-clock strobe for a decoded IN token |
| tok_ep | input | 4 | Endpoint number of the token |
| sw_toggle_wr | input | 1 | Write strobe for the toggle-select bit |
| sw_toggle | input | 1 | Toggle-select value to write |
| sw_txen_wr | input | 1 | Write strobe for transmit enable |
| sw_txen | input | 1 | Transmit enable value to write |
| sw_count_wr | input | 1 | Write strobe for the byte-count field |
| sw_count | input | 4 | Byte-count value to write |
| owner_ep2 | input | 1 | Buffer owner select: 1 = endpoint 2, 0 = endpoint 1 |
| ep_enable | input | 2 | Endpoint enables, bit 0 = endpoint 1, bit 1 = endpoint 2 |
| ep_stall | input | 2 | Endpoint stall bits, same bit order |
| byte_req | input | 1 | Serializer pulse: current byte taken |
| done_ack | input | 1 | Software clear for `tx_done` |
| force_resume | input | 1 | Remote wake-up request |
| rx_k_state | input | 1 | Receiver sees K state on the bus |
| resume_ack | input | 1 | Software clear for `resume_seen` |
| hs_valid | output | 1 | Handshake decision strobe |
| hs_kind | output | 2 | 0 none, 1 data, 2 NAK, 3 STALL |
| pid_data1 | output | 1 | Data PID of the reply: 1 = DATA1 |
| send_len | output | 4 | Byte count of the data reply |
| rd_addr | output | 3 | Buffer read address |
| tx_busy | output | 1 | Bytes of the reply remain to be taken |
| tx_done | output | 1 | Transmit-done flag |
| bus_force_k | output | 1 | Drive K state onto the bus |
| resume_seen | output | 1 | Resume-detected flag |

## Verification
The decision is registered one clock after the token. A wrong endpoint match, owner polarity or priority order therefore shows as a wrong `hs_kind` in the very next clock. That is why the bench places each input combination right beside the reply it expects. A byte counter that is off by one becomes visible as a wrong `rd_addr` after the first `byte_req`, or as `tx_done` rising one pulse early or late. A stale done flag becomes visible at the next IN token, which gets NAK. A toggle bit that hardware changed becomes visible as a wrong `pid_data1` in the following data reply.

// File: rtl/inresp_pkg.sv
package inresp_pkg;

  typedef enum logic [1:0] {
    HS_NONE  = 2'd0,
    HS_DATA  = 2'd1,
    HS_NAK   = 2'd2,
    HS_STALL = 2'd3
  } hs_kind_e;

  // limit a requested byte count to the buffer size
  function automatic int unsigned clamp_count(input int unsigned raw,
                                              input int unsigned cap);
    return (raw > cap) ? cap : raw;
  endfunction

  // priority: disabled -> silent, stalled -> STALL, ready -> DATA, else NAK
  function automatic hs_kind_e pick_handshake(input logic en,
                                              input logic stall,
                                              input logic ready);
    if (!en)        return HS_NONE;
    else if (stall) return HS_STALL;
    else if (ready) return HS_DATA;
    else            return HS_NAK;
  endfunction

endpackage

// File: rtl/inresp_ctlreg.sv
module inresp_ctlreg #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_toggle,
  input  logic             wd_toggle,
  input  logic             wr_txen,
  input  logic             wd_txen,
  input  logic             wr_count,
  input  logic [CNT_W-1:0] wd_count,
  output logic             toggle_q,
  output logic             txen_q,
  output logic [CNT_W-1:0] count_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      toggle_q <= 1'b0;
      txen_q   <= 1'b0;
      count_q  <= '0;
    end else begin
      if (wr_toggle) toggle_q <= wd_toggle;
      if (wr_txen)   txen_q   <= wd_txen;
      if (wr_count)  count_q  <= wd_count;
    end
  end

  // R1
  toggle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_toggle |=> $stable(toggle_q));

endmodule

// File: rtl/inresp_decide.sv
module inresp_decide
  import inresp_pkg::*;
#(
  parameter int EP_W   = 4,
  parameter int NUM_EP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tok_valid,
  input  logic [EP_W-1:0]   tok_ep,
  input  logic [NUM_EP-1:0] ep_en,
  input  logic [NUM_EP-1:0] ep_stall,
  input  logic              owner_sel,
  input  logic              txen,
  input  logic              done,
  output logic              data_go,
  output logic              hs_valid,
  output hs_kind_e          hs_kind
);

  logic [NUM_EP-1:0] hit;
  hs_kind_e          cand [NUM_EP];
  hs_kind_e          kind_n;
  logic              ready_common;

  assign ready_common = txen && !done;

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    // endpoint i serves number i+1; it owns the buffer when owner_sel matches
    assign hit[i]  = (tok_ep == EP_W'(i + 1));
    assign cand[i] = pick_handshake(ep_en[i], ep_stall[i],
                                    ready_common && (owner_sel == (i != 0)));
  end

  always_comb begin
    kind_n = HS_NONE;
    for (int k = 0; k < NUM_EP; k++)
      if (hit[k]) kind_n = cand[k];
  end

  assign data_go = tok_valid && (kind_n == HS_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_valid <= 1'b0;
      hs_kind  <= HS_NONE;
    end else begin
      hs_valid <= tok_valid;
      if (tok_valid) hs_kind <= kind_n;
    end
  end

  // R6
  hs_follows_tok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid |=> hs_valid);
  // R6
  hs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tok_valid |=> !hs_valid);
  // R5
  foreign_ep_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid && (tok_ep != EP_W'(1)) && (tok_ep != EP_W'(2)) |=> hs_kind == HS_NONE);
  // R4
  stall_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid && (tok_ep == EP_W'(1)) && ep_en[0] && ep_stall[0] |=> hs_kind == HS_STALL);

endmodule

// File: rtl/inresp_sender.sv
module inresp_sender
  import inresp_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int BUF_BYTES = 8,
  localparam int ADDR_W   = $clog2(BUF_BYTES),
  localparam int LEN_W    = $clog2(BUF_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_go,
  input  logic              toggle,
  input  logic [CNT_W-1:0]  count,
  input  logic              byte_req,
  input  logic              done_ack,
  output logic [LEN_W-1:0]  send_len,
  output logic              pid_data1,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              tx_busy,
  output logic              tx_done
);

  logic [LEN_W-1:0] len_n;
  logic             last_byte;
  logic             done_set;

  assign len_n     = LEN_W'(clamp_count(32'(count), BUF_BYTES));
  assign last_byte = tx_busy && byte_req && (LEN_W'(rd_addr) == send_len - LEN_W'(1));
  assign done_set  = (data_go && (len_n == '0)) || last_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      send_len  <= '0;
      pid_data1 <= 1'b0;
      rd_addr   <= '0;
      tx_busy   <= 1'b0;
    end else if (data_go) begin
      send_len  <= len_n;
      pid_data1 <= toggle;
      rd_addr   <= '0;
      tx_busy   <= (len_n != '0);
    end else if (last_byte) begin
      tx_busy   <= 1'b0;
    end else if (tx_busy && byte_req) begin
      rd_addr   <= rd_addr + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        tx_done <= 1'b0;
    else if (done_set) tx_done <= 1'b1;
    else if (done_ack) tx_done <= 1'b0;
  end

  // R7
  len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    send_len <= LEN_W'(BUF_BYTES));
  // R8
  addr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |-> (LEN_W'(rd_addr) < send_len));
  // R9
  last_byte_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy && byte_req && (LEN_W'(rd_addr) == send_len - LEN_W'(1)) && !data_go
      |=> tx_done && !tx_busy);
  // R8
  idle_req_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy && !data_go |=> $stable(rd_addr));

endmodule

// File: rtl/inresp_resume.sv
module inresp_resume (
  input  logic clk,
  input  logic rst_n,
  input  logic force_resume,
  input  logic rx_k_state,
  input  logic resume_ack,
  output logic bus_force_k,
  output logic resume_seen
);

  logic own_k;
  assign own_k = force_resume || bus_force_k;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_force_k <= 1'b0;
      resume_seen <= 1'b0;
    end else begin
      bus_force_k <= force_resume;
      if (rx_k_state && !own_k) resume_seen <= 1'b1;
      else if (resume_ack)      resume_seen <= 1'b0;
    end
  end

  // R11
  no_self_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resume_seen) |-> !$past(force_resume));

endmodule

// File: rtl/intr_in_responder.sv
module intr_in_responder
  import inresp_pkg::*;
#(
  parameter int EP_W      = 4,
  parameter int CNT_W     = 4,
  parameter int BUF_BYTES = 8,
  localparam int NUM_EP   = 2,
  localparam int ADDR_W   = $clog2(BUF_BYTES),
  localparam int LEN_W    = $clog2(BUF_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tok_valid,
  input  logic [EP_W-1:0]   tok_ep,
  input  logic              sw_toggle_wr,
  input  logic              sw_toggle,
  input  logic              sw_txen_wr,
  input  logic              sw_txen,
  input  logic              sw_count_wr,
  input  logic [CNT_W-1:0]  sw_count,
  input  logic              owner_ep2,
  input  logic [NUM_EP-1:0] ep_enable,
  input  logic [NUM_EP-1:0] ep_stall,
  input  logic              byte_req,
  input  logic              done_ack,
  input  logic              force_resume,
  input  logic              rx_k_state,
  input  logic              resume_ack,
  output logic              hs_valid,
  output logic [1:0]        hs_kind,
  output logic              pid_data1,
  output logic [LEN_W-1:0]  send_len,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              tx_busy,
  output logic              tx_done,
  output logic              bus_force_k,
  output logic              resume_seen
);

  logic             toggle_q;
  logic             txen_q;
  logic [CNT_W-1:0] count_q;
  logic             data_go;
  hs_kind_e         kind_q;

  inresp_ctlreg #(.CNT_W(CNT_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_toggle (sw_toggle_wr),
    .wd_toggle (sw_toggle),
    .wr_txen   (sw_txen_wr),
    .wd_txen   (sw_txen),
    .wr_count  (sw_count_wr),
    .wd_count  (sw_count),
    .toggle_q  (toggle_q),
    .txen_q    (txen_q),
    .count_q   (count_q)
  );

  inresp_decide #(.EP_W(EP_W), .NUM_EP(NUM_EP)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .tok_valid (tok_valid),
    .tok_ep    (tok_ep),
    .ep_en     (ep_enable),
    .ep_stall  (ep_stall),
    .owner_sel (owner_ep2),
    .txen      (txen_q),
    .done      (tx_done),
    .data_go   (data_go),
    .hs_valid  (hs_valid),
    .hs_kind   (kind_q)
  );

  assign hs_kind = kind_q;

  inresp_sender #(.CNT_W(CNT_W), .BUF_BYTES(BUF_BYTES)) u_snd (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_go   (data_go),
    .toggle    (toggle_q),
    .count     (count_q),
    .byte_req  (byte_req),
    .done_ack  (done_ack),
    .send_len  (send_len),
    .pid_data1 (pid_data1),
    .rd_addr   (rd_addr),
    .tx_busy   (tx_busy),
    .tx_done   (tx_done)
  );

  inresp_resume u_res (
    .clk          (clk),
    .rst_n        (rst_n),
    .force_resume (force_resume),
    .rx_k_state   (rx_k_state),
    .resume_ack   (resume_ack),
    .bus_force_k  (bus_force_k),
    .resume_seen  (resume_seen)
  );

  // R3
  done_blocks_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done && tok_valid |=> hs_kind != 2'd1);

endmodule

// File: tb/test_intr_in_responder.sv
`timescale 1ns/1ps
module test_intr_in_responder;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tok_valid = 1'b0;
  logic [3:0] tok_ep = '0;
  logic       sw_toggle_wr = 1'b0, sw_toggle = 1'b0;
  logic       sw_txen_wr = 1'b0, sw_txen = 1'b0;
  logic       sw_count_wr = 1'b0;
  logic [3:0] sw_count = '0;
  logic       owner_ep2 = 1'b0;
  logic [1:0] ep_enable = '0, ep_stall = '0;
  logic       byte_req = 1'b0, done_ack = 1'b0;
  logic       force_resume = 1'b0, rx_k_state = 1'b0, resume_ack = 1'b0;
  logic       hs_valid, pid_data1, tx_busy, tx_done, bus_force_k, resume_seen;
  logic [1:0] hs_kind;
  logic [3:0] send_len;
  logic [2:0] rd_addr;

  int n_chk = 0;
  int n_bad = 0;

  localparam int K_NONE = 0, K_DATA = 1, K_NAK = 2, K_STALL = 3;

  always #2 clk = ~clk;

  intr_in_responder i_intr_in_responder (
    .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_ep(tok_ep),
    .sw_toggle_wr(sw_toggle_wr), .sw_toggle(sw_toggle),
    .sw_txen_wr(sw_txen_wr), .sw_txen(sw_txen),
    .sw_count_wr(sw_count_wr), .sw_count(sw_count),
    .owner_ep2(owner_ep2), .ep_enable(ep_enable), .ep_stall(ep_stall),
    .byte_req(byte_req), .done_ack(done_ack),
    .force_resume(force_resume), .rx_k_state(rx_k_state), .resume_ack(resume_ack),
    .hs_valid(hs_valid), .hs_kind(hs_kind), .pid_data1(pid_data1),
    .send_len(send_len), .rd_addr(rd_addr), .tx_busy(tx_busy), .tx_done(tx_done),
    .bus_force_k(bus_force_k), .resume_seen(resume_seen)
  );

  task automatic chk(input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // one-clock writes of the software bits
  task automatic wr_toggle(input logic v);
    @(negedge clk); sw_toggle_wr = 1'b1; sw_toggle = v;
    @(negedge clk); sw_toggle_wr = 1'b0;
  endtask
  task automatic wr_txen(input logic v);
    @(negedge clk); sw_txen_wr = 1'b1; sw_txen = v;
    @(negedge clk); sw_txen_wr = 1'b0;
  endtask
  task automatic wr_count(input int v);
    @(negedge clk); sw_count_wr = 1'b1; sw_count = 4'(v);
    @(negedge clk); sw_count_wr = 1'b0;
  endtask

  // token, then the handshake one clock later, then no strobe (R6)
  task automatic token(input int ep, input int exp_kind, input string tag);
    @(negedge clk); tok_valid = 1'b1; tok_ep = 4'(ep);
    @(negedge clk); tok_valid = 1'b0;
    chk(int'(hs_valid), 1, {tag, " R6 hs_valid after token"});
    chk(int'(hs_kind), exp_kind, {tag, " hs_kind"});
    @(negedge clk);
    chk(int'(hs_valid), 0, {tag, " R6 hs_valid one clock only"});
  endtask

  task automatic pulse_byte();
    @(negedge clk); byte_req = 1'b1;
    @(negedge clk); byte_req = 1'b0;
  endtask

  task automatic ack_done();
    @(negedge clk); done_ack = 1'b1;
    @(negedge clk); done_ack = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(int'(hs_valid), 0, "R10 hs_valid after reset");
    chk(int'(tx_done), 0, "R10 tx_done after reset");
    chk(int'(tx_busy), 0, "R10 tx_busy after reset");
    chk(int'(resume_seen), 0, "R10 resume_seen after reset");
    ep_enable = 2'b01; owner_ep2 = 1'b0;
    token(1, K_NAK, "R10 txen cleared gives NAK");
    wr_txen(1'b1);
    token(1, K_DATA, "R10 data after txen only");
    chk(int'(pid_data1), 0, "R10 toggle cleared: DATA0");
    chk(int'(send_len), 0, "R10 count cleared: length 0");
    chk(int'(tx_done), 1, "R9 zero-length sets done with reply");
    chk(int'(tx_busy), 0, "R8 zero-length not busy");
    ack_done();
    chk(int'(tx_done), 0, "R9 done_ack clears");
  endtask

  task automatic t_data_run();
    wr_toggle(1'b1);
    wr_count(3);
    token(1, K_DATA, "R1 three-byte reply");
    chk(int'(pid_data1), 1, "R1 DATA1 from toggle");
    chk(int'(send_len), 3, "R7 length 3");
    chk(int'(rd_addr), 0, "R8 address starts at 0");
    chk(int'(tx_busy), 1, "R8 busy during reply");
    pulse_byte();
    chk(int'(rd_addr), 1, "R8 address 1");
    pulse_byte();
    chk(int'(rd_addr), 2, "R8 address 2");
    chk(int'(tx_done), 0, "R9 done not before last byte");
    pulse_byte();
    chk(int'(tx_done), 1, "R9 done at last byte");
    chk(int'(tx_busy), 0, "R8 busy cleared at last byte");
    token(1, K_NAK, "R3 done set gives NAK");
    ack_done();
    token(1, K_DATA, "R1 toggle not flipped by hardware");
    chk(int'(pid_data1), 1, "R1 still DATA1");
    repeat (3) pulse_byte();
    ack_done();
    wr_txen(1'b0);
    token(1, K_NAK, "R3 txen 0 gives NAK");
    wr_txen(1'b1);
    wr_toggle(1'b0);
  endtask

  task automatic t_owner();
    wr_count(0);
    ep_enable = 2'b11; owner_ep2 = 1'b1;
    token(1, K_NAK, "R2 ep1 not owner gives NAK");
    token(2, K_DATA, "R2 ep2 owner gets data");
    ack_done();
    owner_ep2 = 1'b0;
    token(2, K_NAK, "R2 ep2 not owner gives NAK");
    token(1, K_DATA, "R2 ep1 owner gets data");
    ack_done();
  endtask

  task automatic t_stall_silent();
    ep_stall = 2'b01;
    token(1, K_STALL, "R4 stall beats data");
    wr_txen(1'b0);
    token(1, K_STALL, "R4 stall beats NAK");
    ep_enable = 2'b10;
    token(1, K_NONE, "R5 disabled stalled endpoint silent");
    ep_stall = 2'b00;
    token(1, K_NONE, "R5 disabled endpoint silent");
    ep_enable = 2'b11;
    token(3, K_NONE, "R5 endpoint 3 silent");
    token(0, K_NONE, "R5 endpoint 0 silent");
    wr_txen(1'b1);
  endtask

  task automatic t_clamp();
    wr_count(12);
    token(1, K_DATA, "R7 count 12");
    chk(int'(send_len), 8, "R7 count 12 clamped to 8");
    for (int b = 0; b < 7; b++) pulse_byte();
    chk(int'(rd_addr), 7, "R8 address reaches 7");
    chk(int'(tx_done), 0, "R9 not done before eighth byte");
    pulse_byte();
    chk(int'(tx_done), 1, "R9 done after eighth byte");
    pulse_byte();
    chk(int'(rd_addr), 7, "R8 idle byte_req ignored");
    ack_done();
    wr_count(8);
    token(1, K_DATA, "R7 count 8");
    chk(int'(send_len), 8, "R7 count 8 kept");
    for (int b = 0; b < 8; b++) pulse_byte();
    ack_done();
    wr_count(15);
    token(2 - 1, K_DATA, "R7 count 15");
    chk(int'(send_len), 8, "R7 count 15 clamped to 8");
    for (int b = 0; b < 8; b++) pulse_byte();
    ack_done();
  endtask

  task automatic t_resume();
    @(negedge clk); force_resume = 1'b1;
    @(negedge clk);
    chk(int'(bus_force_k), 1, "R11 K driven after force");
    rx_k_state = 1'b1;
    repeat (3) @(negedge clk);
    chk(int'(resume_seen), 0, "R11 own K not flagged");
    force_resume = 1'b0; rx_k_state = 1'b0;
    repeat (2) @(negedge clk);
    chk(int'(bus_force_k), 0, "R11 K released");
    rx_k_state = 1'b1;
    @(negedge clk); rx_k_state = 1'b0;
    chk(int'(resume_seen), 1, "R11 host K flagged");
    @(negedge clk); resume_ack = 1'b1;
    @(negedge clk); resume_ack = 1'b0;
    chk(int'(resume_seen), 0, "R11 resume_ack clears");
  endtask

  initial begin
    t_reset();
    t_data_run();
    t_owner();
    t_stall_silent();
    t_clamp();
    t_resume();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule